// File: doc/BRIEF.md
# Packet Timestamp Latch

This block records the running time value at the moment a qualifying event packet crosses the MAC. Each direction has its own record. When a packet qualifies on the receive side, or is marked for stamping on the transmit side, and a start-of-frame strobe arrives while that direction is enabled and empty, the 64-bit time is stored and a valid flag rises. From then on that direction is locked. No later packet can overwrite the held value until software reads the upper word of the record. A packet that would have qualified during the lock is counted in a saturating missed-stamp counter.

Frame parsing happens upstream. The receive side gets pre-decoded strobes: an Ethertype-match flag for Ethertype 0x88F7, a UDP event-port flag for destination port 319, and a 4-bit message-type code. A 3-bit mode field in the receive control word uses these strobes to choose which packets qualify. Software reaches the block through a simple word-wide register port. Reads are combinational from the address. A read has a side effect only at the clock edge on which `reg_rd` is high.

Each direction runs a two-state machine. ST_EMPTY means no stamp is held. ST_HELD means a stamp is held and locked. There are three transitions:
- capture: ST_EMPTY to ST_HELD, on an enabled, qualifying start-of-frame.
- release: ST_HELD to ST_EMPTY, on a read of the upper word.
- hold: ST_HELD to ST_HELD, on every other cycle. During hold, a qualifying enabled packet increments the miss counter.

Top module: `pkt_stamp_latch`

## Requirements
- R1: After reset, every register reads zero: both valid flags, both enables, the mode field, the stamp words and the miss counters.
- R2: On a clock edge where `rx_sof` is high, receive is enabled, the packet qualifies and no stamp is held, the value of `time_now` at that edge is stored. From the next cycle, valid (control bit 1) reads 1. The low word (address 1) returns bits 31:0 and the high word (address 2) returns bits 63:32. Transmit works the same way with `tx_sof` and `tx_stamp_req`, using addresses 3, 4 and 5.
- R3: While a direction holds a stamp, a qualifying packet does not change the stored value.
- R4: Reading the high word clears valid at that edge and releases the lock. Reading the low word leaves valid set.
- R5: With the enable bit (control bit 0) clear, no capture happens. Clearing the enable while a stamp is held keeps both the stamp and valid.
- R6: The receive mode is held in control bits 6:4. The codes are:
  - 0: Ethertype match.
  - 1: UDP event-port match.
  - 2: either of those matches.
  - 3: UDP match with message type 0 (Sync).
  - 4: UDP match with message type 1 (Delay_Req).
  - 5 to 7: every packet.
- R7: Receive and transmit lock independently. A capture or release in one direction leaves the other direction's valid flag and stamp unchanged.
- R8: A qualifying packet that arrives while its direction is enabled and held increments that direction's miss counter. The counter saturates at 255. Packets arriving while the direction is disabled are not counted. Address 6 reads `{16'b0, tx_miss[7:0], rx_miss[7:0]}`.
- R9: Writes to address 0 set the receive enable (bit 0) and mode (bits 6:4). Writes to address 3 set the transmit enable (bit 0). The valid bit cannot be written.
- R10: `reg_rdata` always shows the word at `reg_addr`. Address 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 64 | Running time value |
| rx_sof | input | 1 | Receive start-of-frame strobe |
| rx_ethertype_hit | input | 1 | Receive packet carries Ethertype 0x88F7 |
| rx_udp_event_hit | input | 1 | Receive packet is UDP to port 319 |
| rx_msg_type | input | 4 | Decoded message type (0 Sync, 1 Delay_Req) |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| tx_stamp_req | input | 1 | Transmit packet is marked for stamping |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on high-word reads) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |

## Verification
The assertions assume the following about the inputs:
- Match strobes and `time_now` are steady around each clock edge.
- A start-of-frame strobe lasts exactly one cycle per packet.
- `reg_rd` and `reg_wr` are never high together.

The stimulus keeps within these limits. It drives every input once, shortly after a rising edge, and holds each packet strobe for exactly one cycle. Register reads and writes are issued as separate one-cycle operations that never overlap a write.

// File: rtl/psl_pkg.sv
package psl_pkg;
    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_HELD  = 1'b1
    } cap_state_t;

    typedef enum logic [2:0] {
        MODE_L2      = 3'd0,
        MODE_UDP     = 3'd1,
        MODE_EVENT   = 3'd2,
        MODE_V1_SYNC = 3'd3,
        MODE_V1_DREQ = 3'd4,
        MODE_ALL_A   = 3'd5,
        MODE_ALL_B   = 3'd6,
        MODE_ALL_C   = 3'd7
    } rx_mode_t;

    localparam logic [3:0] MSG_SYNC = 4'd0;
    localparam logic [3:0] MSG_DREQ = 4'd1;

    localparam logic [2:0] ADR_RX_CTL = 3'd0;
    localparam logic [2:0] ADR_RX_LO  = 3'd1;
    localparam logic [2:0] ADR_RX_HI  = 3'd2;
    localparam logic [2:0] ADR_TX_CTL = 3'd3;
    localparam logic [2:0] ADR_TX_LO  = 3'd4;
    localparam logic [2:0] ADR_TX_HI  = 3'd5;
    localparam logic [2:0] ADR_MISS   = 3'd6;
endpackage

// File: rtl/psl_rx_classify.sv
module psl_rx_classify
    import psl_pkg::*;
(
    input  rx_mode_t   mode_i,
    input  logic       et_hit_i,
    input  logic       udp_hit_i,
    input  logic [3:0] msg_i,
    output logic       qual_o
);
    always_comb begin
        unique case (mode_i)
            MODE_L2:      qual_o = et_hit_i;
            MODE_UDP:     qual_o = udp_hit_i;
            MODE_EVENT:   qual_o = et_hit_i | udp_hit_i;
            MODE_V1_SYNC: qual_o = udp_hit_i & (msg_i == MSG_SYNC);
            MODE_V1_DREQ: qual_o = udp_hit_i & (msg_i == MSG_DREQ);
            MODE_ALL_A,
            MODE_ALL_B,
            MODE_ALL_C:   qual_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/psl_capture.sv
module psl_capture
    import psl_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int MISS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              sof_i,
    input  logic              qual_i,
    input  logic [TIME_W-1:0] time_i,
    input  logic              release_i,
    output logic              valid_o,
    output logic [TIME_W-1:0] stamp_o,
    output logic [MISS_W-1:0] miss_o
);
    localparam logic [MISS_W-1:0] MISS_MAX = {MISS_W{1'b1}};

    cap_state_t state_q, state_nx;
    logic       hit, take, lost;

    assign hit = en_i & sof_i & qual_i;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_nx;
    end

    // transitions: capture, release, hold
    always_comb begin
        state_nx = state_q;
        take     = 1'b0;
        lost     = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (hit) begin
                    take     = 1'b1;
                    state_nx = ST_HELD;
                end
            end
            ST_HELD: begin
                lost = hit;
                if (release_i) state_nx = ST_EMPTY;
            end
        endcase
    end

    // output data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp_o <= '0;
            miss_o  <= '0;
        end else begin
            if (take) stamp_o <= time_i;
            if (lost && miss_o != MISS_MAX) miss_o <= miss_o + 1'b1;
        end
    end

    assign valid_o = (state_q == ST_HELD);
endmodule

// File: rtl/pkt_stamp_latch.sv
module pkt_stamp_latch
    import psl_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int MISS_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*WORD_W-1:0] time_now,
    input  logic                rx_sof,
    input  logic                rx_ethertype_hit,
    input  logic                rx_udp_event_hit,
    input  logic [3:0]          rx_msg_type,
    input  logic                tx_sof,
    input  logic                tx_stamp_req,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [2:0]          reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata
);
    localparam int TIME_W = 2 * WORD_W;
    localparam int PAD_W  = WORD_W - 2 * MISS_W;
    localparam int NDIR   = 2;

    logic     rx_en_q, tx_en_q, rx_qual;
    rx_mode_t rx_mode_q;
    logic     unused_wdata;

    logic              d_en    [NDIR];
    logic              d_sof   [NDIR];
    logic              d_qual  [NDIR];
    logic              d_rel   [NDIR];
    logic              d_valid [NDIR];
    logic [TIME_W-1:0] d_stamp [NDIR];
    logic [MISS_W-1:0] d_miss  [NDIR];

    assign unused_wdata = ^{reg_wdata[WORD_W-1:7], reg_wdata[3:1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en_q   <= 1'b0;
            rx_mode_q <= MODE_L2;
            tx_en_q   <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == ADR_RX_CTL) begin
                rx_en_q   <= reg_wdata[0];
                rx_mode_q <= rx_mode_t'(reg_wdata[6:4]);
            end
            if (reg_addr == ADR_TX_CTL) tx_en_q <= reg_wdata[0];
        end
    end

    psl_rx_classify u_cls (
        .mode_i    (rx_mode_q),
        .et_hit_i  (rx_ethertype_hit),
        .udp_hit_i (rx_udp_event_hit),
        .msg_i     (rx_msg_type),
        .qual_o    (rx_qual)
    );

    assign d_en[0]   = rx_en_q;
    assign d_sof[0]  = rx_sof;
    assign d_qual[0] = rx_qual;
    assign d_rel[0]  = reg_rd && (reg_addr == ADR_RX_HI);
    assign d_en[1]   = tx_en_q;
    assign d_sof[1]  = tx_sof;
    assign d_qual[1] = tx_stamp_req;
    assign d_rel[1]  = reg_rd && (reg_addr == ADR_TX_HI);

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        psl_capture #(.TIME_W(TIME_W), .MISS_W(MISS_W)) u_cap (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (d_en[d]),
            .sof_i     (d_sof[d]),
            .qual_i    (d_qual[d]),
            .time_i    (time_now),
            .release_i (d_rel[d]),
            .valid_o   (d_valid[d]),
            .stamp_o   (d_stamp[d]),
            .miss_o    (d_miss[d])
        );
    end

    always_comb begin
        unique case (reg_addr)
            ADR_RX_CTL: reg_rdata = {{(WORD_W-7){1'b0}}, rx_mode_q, 2'b00, d_valid[0], rx_en_q};
            ADR_RX_LO:  reg_rdata = d_stamp[0][WORD_W-1:0];
            ADR_RX_HI:  reg_rdata = d_stamp[0][TIME_W-1:WORD_W];
            ADR_TX_CTL: reg_rdata = {{(WORD_W-2){1'b0}}, d_valid[1], tx_en_q};
            ADR_TX_LO:  reg_rdata = d_stamp[1][WORD_W-1:0];
            ADR_TX_HI:  reg_rdata = d_stamp[1][TIME_W-1:WORD_W];
            ADR_MISS:   reg_rdata = {{PAD_W{1'b0}}, d_miss[1], d_miss[0]};
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/psl_checker.sv
module psl_checker
    import psl_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int MISS_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TIME_W-1:0] time_now,
    input logic              reg_rd,
    input logic [2:0]        reg_addr,
    input logic              tx_sof,
    input logic              tx_stamp_req,
    input logic              tx_en,
    input logic              rx_valid,
    input logic              tx_valid,
    input logic [TIME_W-1:0] rx_stamp,
    input logic [TIME_W-1:0] tx_stamp,
    input logic [MISS_W-1:0] rx_miss
);
    localparam logic [MISS_W-1:0] MISS_MAX = {MISS_W{1'b1}};

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tx_sof && tx_stamp_req && !tx_valid) |=> (tx_valid && tx_stamp == $past(time_now)));

    assert_stamp_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> $stable(rx_stamp));

    assert_hi_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADR_RX_HI && rx_valid) |=> !rx_valid);

    assert_lo_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADR_RX_LO && rx_valid) |=> rx_valid);

    assert_no_cap_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !tx_valid) |=> !tx_valid);

    assert_tx_indep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !(reg_rd && reg_addr == ADR_TX_HI)) |=> (tx_valid && $stable(tx_stamp)));

    assert_miss_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_miss == MISS_MAX) |=> (rx_miss == MISS_MAX));
endmodule

bind pkt_stamp_latch psl_checker #(.TIME_W(2*WORD_W), .MISS_W(MISS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .time_now     (time_now),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .tx_sof       (tx_sof),
    .tx_stamp_req (tx_stamp_req),
    .tx_en        (tx_en_q),
    .rx_valid     (d_valid[0]),
    .tx_valid     (d_valid[1]),
    .rx_stamp     (d_stamp[0]),
    .tx_stamp     (d_stamp[1]),
    .rx_miss      (d_miss[0])
);

// File: tb/pkt_stamp_latch_tb.sv
module pkt_stamp_latch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_now = '0;
    logic        rx_sof = 0, rx_ethertype_hit = 0, rx_udp_event_hit = 0;
    logic [3:0]  rx_msg_type = '0;
    logic        tx_sof = 0, tx_stamp_req = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model
    bit          m_rx_en, m_tx_en, m_rx_v, m_tx_v;
    logic [2:0]  m_mode;
    logic [63:0] m_rx_t, m_tx_t;
    int          m_rx_miss, m_tx_miss;

    always #5 clk = ~clk;

    pkt_stamp_latch u_dut (.*);

    function automatic bit qual_fn(input logic [2:0] mode, input bit et, input bit udp, input logic [3:0] msg);
        case (mode)
            3'd0: return et;
            3'd1: return udp;
            3'd2: return et | udp;
            3'd3: return udp && msg == 4'd0;
            3'd4: return udp && msg == 4'd1;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [31:0] rx_ctl_exp();
        return {25'd0, m_mode, 2'b00, m_rx_v, m_rx_en};
    endfunction

    function automatic logic [31:0] miss_exp();
        return {16'd0, m_tx_miss[7:0], m_rx_miss[7:0]};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
        if (a == 3'd2) m_rx_v = 0;
        if (a == 3'd5) m_tx_v = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, {32'd0, d}, {32'd0, exp});
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        if (a == 3'd0) begin m_rx_en = v[0]; m_mode = v[6:4]; end
        if (a == 3'd3) m_tx_en = v[0];
    endtask

    task automatic rx_pkt(input bit et, input bit udp, input logic [3:0] msg, input logic [63:0] t);
        rx_sof = 1; rx_ethertype_hit = et; rx_udp_event_hit = udp; rx_msg_type = msg; time_now = t;
        if (m_rx_en && qual_fn(m_mode, et, udp, msg)) begin
            if (!m_rx_v) begin m_rx_v = 1; m_rx_t = t; end
            else if (m_rx_miss < 255) m_rx_miss++;
        end
        @(posedge clk); #1;
        rx_sof = 0; rx_ethertype_hit = 0; rx_udp_event_hit = 0;
    endtask

    task automatic tx_pkt(input bit mark, input logic [63:0] t);
        tx_sof = 1; tx_stamp_req = mark; time_now = t;
        if (m_tx_en && mark) begin
            if (!m_tx_v) begin m_tx_v = 1; m_tx_t = t; end
            else if (m_tx_miss < 255) m_tx_miss++;
        end
        @(posedge clk); #1;
        tx_sof = 0; tx_stamp_req = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h1588));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state, R10 unmapped address
        for (int a = 0; a < 8; a++) rd_chk("R1 reset / R10", 3'(a), 32'd0);

        // R9 valid bit not writable, R2 capture
        wr(3'd0, 32'h0000_0003);
        rd_chk("R9 valid read-only", 3'd0, rx_ctl_exp());
        rx_pkt(1, 0, 4'd0, 64'h1111_2222_3333_4444);
        rd_chk("R2 rx valid set", 3'd0, rx_ctl_exp());
        rd_chk("R4 low read keeps lock", 3'd1, 32'h3333_4444);
        rd_chk("R4 valid after low read", 3'd0, rx_ctl_exp());
        rx_pkt(1, 0, 4'd0, 64'h5555_6666_7777_8888);
        rd_chk("R3 stamp unchanged", 3'd1, 32'h3333_4444);
        rd_chk("R8 miss counted", 3'd6, miss_exp());
        rd_chk("R2 high word", 3'd2, 32'h1111_2222);
        rd_chk("R4 released", 3'd0, rx_ctl_exp());

        // R5 disable while held
        rx_pkt(1, 0, 4'd0, 64'hAAAA_0000_BBBB_0001);
        wr(3'd0, 32'h0000_0000);
        rd_chk("R5 valid kept when disabled", 3'd0, rx_ctl_exp());
        rx_pkt(1, 1, 4'd0, 64'hDEAD_BEEF_0000_0000);
        rd_chk("R5 R8 no miss when disabled", 3'd6, miss_exp());
        rd_chk("R5 stamp kept", 3'd2, 32'hAAAA_0000);
        rx_pkt(1, 1, 4'd0, 64'h0123_4567_89AB_CDEF);
        rd_chk("R5 no capture disabled", 3'd0, rx_ctl_exp());

        // R6 v1 modes
        wr(3'd0, 32'h0000_0031);
        rx_pkt(0, 1, 4'd1, 64'h1);
        rd_chk("R6 sync mode rejects delay_req", 3'd0, rx_ctl_exp());
        rx_pkt(0, 1, 4'd0, 64'h2);
        rd_chk("R6 sync mode accepts sync", 3'd0, rx_ctl_exp());
        rd_chk("R6 release", 3'd2, 32'd0);

        // R7 tx independent
        wr(3'd3, 32'h1);
        tx_pkt(1, 64'hFEED_0000_CAFE_0001);
        rd_chk("R7 rx untouched by tx", 3'd0, rx_ctl_exp());
        rd_chk("R7 tx valid", 3'd3, {30'd0, m_tx_v, m_tx_en});
        rd_chk("R7 tx low", 3'd4, 32'hCAFE_0001);
        rd_chk("R7 tx high", 3'd5, 32'hFEED_0000);

        // R8 saturation
        wr(3'd0, 32'h0000_0051);
        rx_pkt(0, 0, 4'd5, 64'h77);
        for (int i = 0; i < 260; i++) rx_pkt(0, 0, 4'd5, 64'(i));
        rd_chk("R8 saturate", 3'd6, miss_exp());
        rd_chk("R8 stamp held", 3'd1, 32'h77);

        // random phase, R2 R3 R4 R6 R7 R9 R10
        for (int i = 0; i < 600; i++) begin
            int op;
            op = int'($urandom % 9);
            case (op)
                0, 1: rx_pkt(1'($urandom), 1'($urandom), 4'($urandom % 3), {$urandom, $urandom});
                2: tx_pkt(1'($urandom), {$urandom, $urandom});
                3: rd_chk("R2 R3 rand rx low", 3'd1, m_rx_t[31:0]);
                4: rd_chk("R4 rand rx high", 3'd2, m_rx_t[63:32]);
                5: wr(3'd0, {25'd0, 3'($urandom), 2'b11, 1'(($urandom % 4) != 0)});
                6: rd_chk("R6 R9 rand rx ctl", 3'd0, rx_ctl_exp());
                7: rd_chk("R7 rand tx high", 3'd5, m_tx_t[63:32]);
                default: rd_chk("R8 R10 rand miss", 3'd6, miss_exp());
            endcase
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule